// File: doc/BRIEF.md
# Clock Ratio Divider with Phase Offset

This block derives a slower timing grid from a fast input clock. It emits `div_en`, a registered clock enable that is high for one cycle out of every N. It also emits `div_clk`, a registered divided clock that rises in the cycle where the enable is high. The divide value N runs from 1 to 8. Logic that runs on the input clock uses the enable to step once per grid period. The divided clock serves any place that needs a square-ish waveform at the grid rate.

A sync pulse realigns the grid. After a sync, the enable lands a programmable number of input cycles later, from 0 to 7. The ratio and offset fields are only staged until an apply strobe arrives. The strobe moves both fields into the active setting on the same edge, so software can never observe a mix of old ratio and new offset.

Top module: `clk_ratio_div`

## Requirements
- R1: While `rst` is high, both outputs are low at every edge. Reset also clears the active setting, so with no apply the block divides by 1 after reset.
- R2: With no sync or apply, `div_en` is high for exactly one cycle in every N cycles, where N = active ratio field + 1. A ratio field of 0 means divide by 1 and 7 means divide by 8.
- R3: With N = 1, `div_en` and `div_clk` are high in every cycle, whatever the offset field holds.
- R4: Values on `cfg_ratio` and `cfg_phase` have no effect on the outputs unless `apply` is high at that edge.
- R5: When `sync_in` is high at an edge, `div_en` is high in the cycle that begins P edges after that edge, where P is the effective offset. In particular, P = 0 makes it high right after the sync edge.
- R6: The effective offset is the offset field modulo N. For example, an offset of N behaves like an offset of 0.
- R7: Within each grid period, `div_clk` is high for floor(N/2) cycles starting with the `div_en` cycle and low for the rest. For N = 1 it stays high.
- R8: When `apply` and `sync_in` are high at the same edge, the realignment uses the newly applied ratio and offset.
- R9: When `apply` is high without `sync_in`, the phase count keeps running. If the count has reached or passed the new N-1, it wraps to the start of a period at that edge.
- R10: A sync without apply realigns using the active setting, not the staged field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ratio | input | FIELD_W | Staged ratio field (N-1) |
| cfg_phase | input | FIELD_W | Staged offset field in input cycles |
| apply | input | 1 | Transfer strobe moving both fields to the active setting |
| sync_in | input | 1 | Grid realignment pulse |
| div_en | output | 1 | One-cycle enable per grid period |
| div_clk | output | 1 | Divided clock |

## Verification
Two functions can fall in the same cycle: the transfer of new settings and the realignment by sync. The sweep provokes this collision on purpose by raising `apply` and `sync_in` together for every ratio and offset pair. In each case the field lines carry the new values only in that cycle and unrelated values afterwards. The bench judges the following cycles against a count model built from R5 to R8: the enable and clock pattern must follow the new N and the new offset, never the old setting and never the values left on the field lines.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  // default width of the ratio and offset fields
  localparam int unsigned CDIV_FW_DEF = 3;

  // what the phase counter does at the next edge
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_STEP,
    ACT_WRAP,
    ACT_LOAD
  } cnt_act_e;
endpackage

// File: rtl/cdiv_shadow.sv
module cdiv_shadow #(
  parameter int unsigned FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          apply,
  input  logic [FW-1:0] cfg_ratio,
  input  logic [FW-1:0] cfg_phase,
  output logic [FW-1:0] act_ratio,
  output logic [FW-1:0] act_phase
);
  // both fields move together so the pair is always consistent
  always_ff @(posedge clk) begin
    if (rst) begin
      act_ratio <= '0;
      act_phase <= '0;
    end else if (apply) begin
      act_ratio <= cfg_ratio;
      act_phase <= cfg_phase;
    end
  end
endmodule

// File: rtl/cdiv_plan.sv
module cdiv_plan #(
  parameter int unsigned FW = 3,
  localparam int unsigned NW = FW + 1
) (
  input  logic          apply,
  input  logic [FW-1:0] cfg_ratio,
  input  logic [FW-1:0] cfg_phase,
  input  logic [FW-1:0] act_ratio,
  input  logic [FW-1:0] act_phase,
  output logic [NW-1:0] last,
  output logic [NW-1:0] reload,
  output logic [NW-1:0] hi_len
);
  logic [FW-1:0] sel_ratio;
  logic [FW-1:0] sel_phase;
  logic [NW-1:0] div_n;
  logic [NW-1:0] ph_mod;

  always_comb begin
    // the edge that applies new fields already runs on them
    sel_ratio = apply ? cfg_ratio : act_ratio;
    sel_phase = apply ? cfg_phase : act_phase;
    div_n     = {1'b0, sel_ratio} + NW'(1);
    last      = {1'b0, sel_ratio};
    ph_mod    = {1'b0, sel_phase} % div_n;
    // count value that reaches zero after ph_mod more edges
    reload    = (ph_mod == '0) ? '0 : (div_n - ph_mod);
    hi_len    = (div_n == NW'(1)) ? NW'(1) : (div_n >> 1);
  end
endmodule

// File: rtl/cdiv_count.sv
module cdiv_count #(
  parameter int unsigned FW = 3,
  localparam int unsigned NW = FW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_in,
  input  logic [NW-1:0] last,
  input  logic [NW-1:0] reload,
  output logic [NW-1:0] cnt_d
);
  import cdiv_pkg::*;

  logic [NW-1:0] cnt_q;
  cnt_act_e      act;

  always_comb begin
    if (sync_in)          act = ACT_LOAD;
    else if (cnt_q >= last) act = ACT_WRAP;
    else                  act = ACT_STEP;
    case (act)
      ACT_LOAD: cnt_d = reload;
      ACT_WRAP: cnt_d = '0;
      ACT_STEP: cnt_d = cnt_q + NW'(1);
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cdiv_outreg.sv
module cdiv_outreg #(
  parameter int unsigned FW = 3,
  localparam int unsigned NW = FW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] cnt_d,
  input  logic [NW-1:0] hi_len,
  output logic          div_en,
  output logic          div_clk
);
  // outputs decode the next count so they line up with it
  always_ff @(posedge clk) begin
    if (rst) begin
      div_en  <= 1'b0;
      div_clk <= 1'b0;
    end else begin
      div_en  <= (cnt_d == '0);
      div_clk <= (cnt_d < hi_len);
    end
  end
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int unsigned FIELD_W = cdiv_pkg::CDIV_FW_DEF,
  localparam int unsigned NW = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] cfg_ratio,
  input  logic [FIELD_W-1:0] cfg_phase,
  input  logic               apply,
  input  logic               sync_in,
  output logic               div_en,
  output logic               div_clk
);
  logic [FIELD_W-1:0] act_ratio;
  logic [FIELD_W-1:0] act_phase;
  logic [NW-1:0]      last;
  logic [NW-1:0]      reload;
  logic [NW-1:0]      hi_len;
  logic [NW-1:0]      cnt_d;

  cdiv_shadow #(.FW(FIELD_W)) u_shadow (
    .clk(clk), .rst(rst), .apply(apply),
    .cfg_ratio(cfg_ratio), .cfg_phase(cfg_phase),
    .act_ratio(act_ratio), .act_phase(act_phase)
  );

  cdiv_plan #(.FW(FIELD_W)) u_plan (
    .apply(apply), .cfg_ratio(cfg_ratio), .cfg_phase(cfg_phase),
    .act_ratio(act_ratio), .act_phase(act_phase),
    .last(last), .reload(reload), .hi_len(hi_len)
  );

  cdiv_count #(.FW(FIELD_W)) u_count (
    .clk(clk), .rst(rst), .sync_in(sync_in),
    .last(last), .reload(reload), .cnt_d(cnt_d)
  );

  cdiv_outreg #(.FW(FIELD_W)) u_out (
    .clk(clk), .rst(rst), .cnt_d(cnt_d), .hi_len(hi_len),
    .div_en(div_en), .div_clk(div_clk)
  );
endmodule

// File: rtl/clk_ratio_div_chk.sv
module clk_ratio_div_chk #(
  parameter int unsigned FW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          apply,
  input logic          sync_in,
  input logic [FW-1:0] cfg_ratio,
  input logic [FW-1:0] cfg_phase,
  input logic [FW-1:0] act_ratio,
  input logic [FW-1:0] act_phase,
  input logic          div_en,
  input logic          div_clk
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!div_en && !div_clk));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    (div_en && !sync_in && !apply && act_ratio != '0) |=> !div_en);

  p_unit_every_r3: assert property (@(posedge clk) disable iff (rst)
    ((apply && cfg_ratio == '0) || (!apply && act_ratio == '0)) |=> div_en);

  p_hold_cfg_r4: assert property (@(posedge clk) disable iff (rst)
    !apply |=> ($stable(act_ratio) && $stable(act_phase)));

  p_sync_now_r5: assert property (@(posedge clk) disable iff (rst)
    (sync_in && !apply && act_phase == '0) |=> div_en);

  p_phase_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (sync_in && !apply && ({1'b0, act_phase} == {1'b0, act_ratio} + 1'b1)) |=> div_en);

  p_clk_at_en_r7: assert property (@(posedge clk) disable iff (rst)
    div_en |-> div_clk);

  p_joint_load_r8: assert property (@(posedge clk) disable iff (rst)
    (sync_in && apply && cfg_phase == '0) |=> div_en);
endmodule

bind clk_ratio_div clk_ratio_div_chk #(.FW(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .apply(apply), .sync_in(sync_in),
  .cfg_ratio(cfg_ratio), .cfg_phase(cfg_phase),
  .act_ratio(act_ratio), .act_phase(act_phase),
  .div_en(div_en), .div_clk(div_clk)
);

// File: tb/clk_ratio_div_test.sv
module clk_ratio_div_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cfg_ratio = '0;
  logic [2:0] cfg_phase = '0;
  logic       apply = 1'b0;
  logic       sync_in = 1'b0;
  logic       div_en;
  logic       div_clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // requirement model state
  int m_r = 0;
  int m_p = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  clk_ratio_div #(.FIELD_W(3)) uut (
    .clk(clk), .rst(rst), .cfg_ratio(cfg_ratio), .cfg_phase(cfg_phase),
    .apply(apply), .sync_in(sync_in), .div_en(div_en), .div_clk(div_clk)
  );

  task automatic check(input string tag, input bit exp_en, input bit exp_clk);
    total++;
    if (div_en !== exp_en || div_clk !== exp_clk) begin
      bad++;
      $display("FAIL %s t=%0t actual en=%0b clk=%0b expected en=%0b clk=%0b",
               tag, $time, div_en, div_clk, exp_en, exp_clk);
    end
  endtask

  // drive one cycle, advance the model by the requirement rules, check
  task automatic step(input bit ap, input int r, input int p, input bit sy,
                      input string tag);
    int n;
    int ph;
    apply = ap; cfg_ratio = 3'(r); cfg_phase = 3'(p); sync_in = sy;
    @(posedge clk);
    if (ap) begin m_r = r; m_p = p; end
    n  = m_r + 1;
    ph = m_p % n;
    if (sy)                m_cnt = (n - ph) % n;
    else if (m_cnt >= n-1) m_cnt = 0;
    else                   m_cnt = m_cnt + 1;
    @(negedge clk);
    check(tag, m_cnt == 0, m_cnt < ((n == 1) ? 1 : n / 2));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset wins over apply, outputs stay low
    @(negedge clk);
    apply = 1'b1; cfg_ratio = 3'd5; cfg_phase = 3'd2; sync_in = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", 1'b0, 1'b0);
    end
    rst = 1'b0;
    // R1: active setting cleared, divide by 1 with fields not applied
    for (int i = 0; i < 4; i++) step(0, 6, 3, 0, "R1");

    // R3: divide by 1 ignores the offset
    step(1, 0, 5, 1, "R3");
    for (int i = 0; i < 5; i++) step(0, 0, 0, (i == 2), "R3");

    // R8 collision sweep over every ratio and offset, then R5/R6/R2/R7
    for (int r = 0; r < 8; r++) begin
      for (int p = 0; p < 8; p++) begin
        step(1, r, p, 1, "R8");
        for (int j = 0; j < r + 1; j++)
          step(0, r ^ 5, p ^ 3, 0, (p > r) ? "R6" : "R5");
        for (int j = 0; j < r + 2; j++)
          step(0, 7 - r, 7 - p, 0, (j < r + 1) ? "R7" : "R2");
      end
    end

    // R4: fields move without apply, pattern must stay at N=4
    step(1, 3, 1, 1, "R4");
    for (int i = 0; i < 10; i++) step(0, i % 8, (i * 3) % 8, 0, "R4");

    // R10: sync alone uses active offset 2, not staged 0
    step(1, 4, 2, 0, "R10");
    for (int i = 0; i < 3; i++) step(0, 4, 0, 0, "R10");
    step(0, 1, 0, 1, "R10");
    for (int i = 0; i < 7; i++) step(0, 1, 0, 0, "R10");

    // R9: apply without sync, count past new last wraps
    step(1, 7, 0, 1, "R9");
    for (int i = 0; i < 5; i++) step(0, 7, 0, 0, "R9");
    step(1, 2, 0, 0, "R9");
    for (int i = 0; i < 6; i++) step(0, 2, 0, 0, "R9");
    // R9: apply with a larger ratio keeps counting
    step(1, 6, 0, 0, "R9");
    for (int i = 0; i < 9; i++) step(0, 6, 0, 0, "R9");

    // R5: repeated mid-period syncs with the active offset
    step(1, 5, 4, 0, "R5");
    for (int k = 0; k < 3; k++) begin
      step(0, 5, 4, 1, "R5");
      for (int i = 0; i < k + 2; i++) step(0, 5, 4, 0, "R5");
    end

    apply = 1'b0; sync_in = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule